// File: doc/BRIEF.md
# Multidrop Address-Hunt Receive Filter

This block sits behind the deserializer of a 9-bit serial receiver on a shared multidrop line. Each completed character arrives with a one-cycle valid strobe. The block decides whether that character reaches the receive holding register and raises the receive-ready indication, or whether it is dropped.

Filtering is controlled by an address-hunt enable that software writes through a control word. While hunting, only characters whose top bit (the 9th bit, the address marker) is 1 are passed. Software inspects each passed character. When the address belongs to this node, software clears the enable, and from then on every character is taken whatever its marker bit. A dropped character leaves no trace. An accepted character that lands while the previous one is still unread raises an overrun flag.

Top module: `multidrop_rx_filter`

## Requirements
- R1: With the hunt enable at 0, every character presented with `char_valid` is written to `rx_data`, and `rx_ready` is 1 in the cycle after the strobe.
- R2: With the hunt enable at 1, a character whose bit 8 (the top bit) is 0 is dropped: `rx_data`, `rx_ready` and `rx_overrun` keep their values.
- R3: With the hunt enable at 1, a character whose bit 8 is 1 is written to `rx_data`, and `rx_ready` is set in the cycle after the strobe.
- R4: Once software writes the enable back to 0, all following characters are accepted whatever their bit 8.
- R5: The hunt enable is bit 2 of `ctl_wdata`, loaded when `ctl_we` is 1, and reset to 0. Other bits of `ctl_wdata` are ignored. `hunt_en` shows its current value.
- R6: A pulse on `rx_read` clears `rx_ready` in the next cycle, unless a character is accepted in the same cycle, in which case `rx_ready` stays 1.
- R7: An accepted character that arrives while `rx_ready` is 1 and `rx_read` is 0 sets `rx_overrun`. Under the default policy the newer character replaces the held one. `rx_overrun` clears on `rx_read`.
- R8: A control write in the same cycle as a character strobe does not affect that character; the character is filtered with the previous enable value.
- R9: After reset, `rx_data` is 0, `rx_ready` is 0 and `rx_overrun` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| char_valid | input | 1 | One-cycle strobe for a completed character |
| char_data | input | 9 | Completed character; bit 8 is the address marker |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word; bit 2 is the hunt enable |
| rx_read | input | 1 | Read of the holding register |
| hunt_en | output | 1 | Current hunt enable |
| rx_data | output | 9 | Receive holding register |
| rx_ready | output | 1 | Holding register has an unread character (interrupt request) |
| rx_overrun | output | 1 | An accepted character arrived before the previous one was read |

## Verification
The assertions check the following on every cycle: dropped characters leave the holding register, ready flag and overrun flag untouched; accepted characters set ready; an unread accept raises overrun; and a read without an accept clears ready. Other behaviour shows only in the bench scenarios. These are the handover from hunting to normal reception after software clears the enable, the old enable value being used when a control write coincides with a strobe, and the replacement of data under overrun. Random stimulus with frequent enable toggles compares the outputs against a bench model after every cycle.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
   // What the holding register does when an accept meets unread data
   typedef enum logic {
      OVR_TAKE_NEW = 1'b0,
      OVR_KEEP_OLD = 1'b1
   } ovr_policy_e;
endpackage

// File: rtl/mdrop_hunt_ctl.sv
module mdrop_hunt_ctl #(
   parameter int CTL_W    = 32,
   parameter int HUNT_BIT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic             hunt_q
);
   if (HUNT_BIT >= CTL_W) begin : g_bad_bit
      $error("HUNT_BIT must index inside the control word");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hunt_q <= 1'b0;
      else if (ctl_we) hunt_q <= ctl_wdata[HUNT_BIT];
   end

   // R5
   hunt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> hunt_q == $past(ctl_wdata[HUNT_BIT]));
endmodule

// File: rtl/mdrop_gate.sv
module mdrop_gate #(
   parameter int CHAR_W = 9
) (
   input  logic              char_valid,
   input  logic [CHAR_W-1:0] char_data,
   input  logic              hunt_q,
   output logic              accept
);
   localparam int MARK = CHAR_W - 1;

   if (CHAR_W < 2) begin : g_bad_width
      $error("CHAR_W must leave room for a marker bit above the payload");
   end

   // the enable in force before this edge decides, so a same-cycle write waits
   always_comb accept = char_valid && (!hunt_q || char_data[MARK]);
endmodule

// File: rtl/mdrop_hold.sv
module mdrop_hold #(
   parameter int                     CHAR_W     = 9,
   parameter mdrop_pkg::ovr_policy_e OVR_POLICY = mdrop_pkg::OVR_TAKE_NEW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [CHAR_W-1:0] char_data,
   input  logic              rx_read,
   output logic [CHAR_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              rx_overrun
);
   logic load;
   logic collide;

   always_comb collide = accept && rx_ready && !rx_read;

   if (OVR_POLICY == mdrop_pkg::OVR_TAKE_NEW) begin : g_take_new
      always_comb load = accept;
   end else begin : g_keep_old
      always_comb load = accept && !collide;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data    <= '0;
         rx_ready   <= 1'b0;
         rx_overrun <= 1'b0;
      end else begin
         if (load) rx_data <= char_data;
         if (accept)       rx_ready <= 1'b1;
         else if (rx_read) rx_ready <= 1'b0;
         if (collide)      rx_overrun <= 1'b1;
         else if (rx_read) rx_overrun <= 1'b0;
      end
   end

   // R3
   accept_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> rx_ready);
   // R6
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_read && !accept) |=> !rx_ready);
   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && rx_ready && !rx_read) |=> rx_overrun);
endmodule

// File: rtl/multidrop_rx_filter.sv
module multidrop_rx_filter #(
   parameter int                     CHAR_W     = 9,
   parameter int                     CTL_W      = 32,
   parameter int                     HUNT_BIT   = 2,
   parameter mdrop_pkg::ovr_policy_e OVR_POLICY = mdrop_pkg::OVR_TAKE_NEW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              char_valid,
   input  logic [CHAR_W-1:0] char_data,
   input  logic              ctl_we,
   input  logic [CTL_W-1:0]  ctl_wdata,
   input  logic              rx_read,
   output logic              hunt_en,
   output logic [CHAR_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              rx_overrun
);
   localparam int MARK = CHAR_W - 1;

   logic accept;

   mdrop_hunt_ctl #(.CTL_W(CTL_W), .HUNT_BIT(HUNT_BIT)) u_ctl (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .hunt_q(hunt_en));

   mdrop_gate #(.CHAR_W(CHAR_W)) u_gate (
      .char_valid(char_valid), .char_data(char_data), .hunt_q(hunt_en),
      .accept(accept));

   mdrop_hold #(.CHAR_W(CHAR_W), .OVR_POLICY(OVR_POLICY)) u_hold (
      .clk(clk), .rst_n(rst_n), .accept(accept), .char_data(char_data),
      .rx_read(rx_read), .rx_data(rx_data), .rx_ready(rx_ready),
      .rx_overrun(rx_overrun));

   // R2
   drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (char_valid && hunt_en && !char_data[MARK] && !rx_read)
      |=> $stable(rx_data) && $stable(rx_ready) && $stable(rx_overrun));
   // R1
   open_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (char_valid && !hunt_en) |=> rx_ready && rx_data == $past(char_data));
endmodule

// File: tb/tb_multidrop_rx_filter.sv
module tb_multidrop_rx_filter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       char_valid = 1'b0;
   logic [8:0] char_data = '0;
   logic       ctl_we = 1'b0;
   logic [31:0] ctl_wdata = '0;
   logic       rx_read = 1'b0;
   logic       hunt_en;
   logic [8:0] rx_data;
   logic       rx_ready;
   logic       rx_overrun;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic       m_hunt = 1'b0;
   logic [8:0] m_data = '0;
   logic       m_ready = 1'b0;
   logic       m_ovr = 1'b0;

   always #10 clk = ~clk;

   multidrop_rx_filter dut (
      .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .rx_read(rx_read),
      .hunt_en(hunt_en), .rx_data(rx_data), .rx_ready(rx_ready),
      .rx_overrun(rx_overrun));

   function automatic logic model_accept(logic v, logic [8:0] d, logic h);
      return v && (!h || d[8]);
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      chk({tag, " data"},  32'(rx_data), 32'(m_data));
      chk({tag, " ready"}, 32'(rx_ready), 32'(m_ready));
      chk({tag, " ovr"},   32'(rx_overrun), 32'(m_ovr));
      chk({tag, " hunt"},  32'(hunt_en), 32'(m_hunt));
   endtask

   // drive at negedge, one edge, update model, compare after the edge
   task automatic step(string tag, logic v, logic [8:0] d, logic rd,
                       logic we, logic [31:0] wd);
      logic acc;
      @(negedge clk);
      char_valid = v; char_data = d; rx_read = rd; ctl_we = we; ctl_wdata = wd;
      acc = model_accept(v, d, m_hunt);
      @(posedge clk);
      #2;
      if (acc && m_ready && !rd) m_ovr = 1'b1;
      else if (rd)               m_ovr = 1'b0;
      if (acc) begin m_data = d; m_ready = 1'b1; end
      else if (rd) m_ready = 1'b0;
      if (we) m_hunt = wd[2];
      char_valid = 1'b0; rx_read = 1'b0; ctl_we = 1'b0;
      check_all(tag);
   endtask

   initial begin
      #(20 * 50000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = 32'd1234;
      void'($urandom(seed));
      repeat (3) @(posedge clk);
      #2;
      check_all("R9 reset");
      @(negedge clk) rst_n = 1'b1;
      // R1 open reception
      step("R1 open 0xx", 1, 9'h055, 0, 0, 0);
      step("R1 open 1xx", 1, 9'h1A3, 1, 0, 0);
      // R5 only bit 2 matters
      step("R5 other bits", 0, 0, 1, 1, 32'hFFFF_FFFB);
      step("R5 set bit2", 0, 0, 0, 1, 32'h0000_0004);
      // R2 drop while hunting, with data held and ready set
      step("R2 load addr", 1, 9'h101, 0, 0, 0);
      step("R2 drop", 1, 9'h0EE, 0, 0, 0);
      step("R2 drop again", 1, 9'h011, 0, 0, 0);
      step("R6 read", 0, 0, 1, 0, 0);
      step("R2 drop idle", 1, 9'h0FF, 0, 0, 0);
      // R3 address accepted
      step("R3 addr", 1, 9'h1C4, 0, 0, 0);
      // R7 overrun: second address unread
      step("R7 overrun", 1, 9'h1C5, 0, 0, 0);
      step("R7 read clears", 0, 0, 1, 0, 0);
      // R6 read and accept in same cycle
      step("R6 prime", 1, 9'h1AA, 0, 0, 0);
      step("R6 read+accept", 1, 9'h1BB, 1, 0, 0);
      // R8 write with character: old setting applies (hunt on, MSB 0 dropped)
      step("R8 clear+drop", 1, 9'h033, 1, 1, 32'h0);
      // R4 after clear all accepted
      step("R4 data 0", 1, 9'h044, 1, 0, 0);
      step("R4 data 1", 1, 9'h1FE, 1, 0, 0);
      // R8 set with character: old (off) setting applies, char taken
      step("R8 set+take", 1, 9'h066, 1, 1, 32'h4);
      step("R8 now hunting", 1, 9'h077, 0, 0, 0);
      // random mix
      for (int i = 0; i < 400; i++) begin
         logic v, rd, we;
         logic [8:0] d;
         logic [31:0] w;
         v  = ($urandom % 3) != 0;
         d  = 9'($urandom);
         rd = ($urandom % 4) == 0;
         we = ($urandom % 12) == 0;
         w  = $urandom;
         step("R1-mix random", v, d, rd, we, w);
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule